// File: doc/BRIEF.md
# Multiframe Clock Generator with SYSREF Alignment

This block produces the local multiframe clock of a multi-lane serial converter link. The link datapath carries `DPW` octets per clock cycle, so the block counts multiframe position in beats of `DPW` octets. It flags, with a one-cycle pulse, each cycle whose octet group opens a multiframe. The multiframe length is programmed in octets as F×K−1, where F×K is a multiple of `DPW`.

In the mode that uses SYSREF, the block detects the rising edges of the external SYSREF signal. The first edge it captures re-phases the multiframe counter, so that the multiframe boundary falls a programmed number of octets after the edge. Each later edge is compared against the phase that was set up, and a status bit records any edge that is off phase. In the free-running mode, SYSREF is ignored entirely and the counter runs on its own. A link enable holds the whole block idle and clears its status. Separate strobes acknowledge the two status bits.

Top module: `lmfc_sysref_align`

## Requirements
- R1: While `link_en` is 0, `lmfc_edge` is 0 and the multiframe counter is held at beat 0. `sr_detected`, `sr_align_err` and `lmfc_aligned` are 0 from the clock edge after `link_en` is sampled 0. After reset all outputs are 0.
- R2: With the link enabled and no capture, `lmfc_edge` is 1 in the first enabled cycle and then once every N = (`mf_len`+1)/`DPW` cycles.
- R3: `sysref` passes through two register stages, and an event is a 0-to-1 change between consecutive synchronized samples. If `sysref` is first sampled high at clock edge E0, the event is acted on at clock edge E2. `sr_detected` reads 1 after E2.
- R4: On the first captured event, the counter is loaded so that `lmfc_edge` is 1 in the cycle that starts at clock edge E(2 + `lmfc_ofs`/`DPW`), and then every N cycles. An offset of 0 puts the boundary at E2.
- R5: `lmfc_aligned` rises together with `sr_detected` on the first capture. It stays 1 until the link is disabled.
- R6: A later event whose E0 lies a whole number of multiframes after the first event's E0 leaves `sr_align_err` at 0 and does not move the multiframe phase.
- R7: A later event at any other phase sets `sr_align_err` (visible after E2). The multiframe phase stays unchanged.
- R8: A 1 on `clr_detect` or `clr_align_err` clears the matching status bit at the next clock edge. If a new event sets the bit at that same edge, the set wins.
- R9: With `sysref_dis` at 1, SYSREF events set no status bit and do not alter the multiframe phase.
- R10: A `sysref` held high produces a single event. No further status change follows until `sysref` has gone low and high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| sysref | input | 1 | External SYSREF, asynchronous |
| link_en | input | 1 | 1 enables the link; 0 holds the block idle and clears status |
| sysref_dis | input | 1 | 1 ignores SYSREF (free-running mode) |
| mf_len | input | CNT_W | Octets per multiframe minus one (F×K−1) |
| lmfc_ofs | input | CNT_W | Octets from SYSREF edge to multiframe boundary, multiple of DPW |
| clr_detect | input | 1 | Strobe that clears `sr_detected` |
| clr_align_err | input | 1 | Strobe that clears `sr_align_err` |
| lmfc_edge | output | 1 | One-cycle multiframe boundary pulse |
| lmfc_aligned | output | 1 | SYSREF captured and multiframe clock aligned |
| sr_detected | output | 1 | SYSREF event observed |
| sr_align_err | output | 1 | SYSREF event seen off the established phase |

## Verification
A wrong counter load makes every following `lmfc_edge` pulse land on the wrong cycle. The error shows from the first boundary after capture, at most N cycles later, so the bench checks pulse positions cycle by cycle. A stale or wrongly cleared phase reference shows as a spurious or missing `sr_align_err` two cycles after a later SYSREF edge. A re-phase on a later edge shows as a shifted boundary within one multiframe. A broken edge detector or synchronizer depth shifts the `sr_detected` rise by a cycle, and the bench samples that exact cycle.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sr_sync_t;

    typedef struct packed {
        logic captured;
        logic detected;
        logic align_err;
    } sr_status_t;

endpackage

// File: rtl/lmfc_sr_edge.sv
module lmfc_sr_edge (
    input  logic clk,
    input  logic rst,
    input  logic sysref_i,
    output logic rise_o
);
    import lmfc_pkg::*;

    sr_sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = sysref_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.prev;
endmodule

// File: rtl/lmfc_beat_ctr.sv
module lmfc_beat_ctr #(
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              load_i,
    input  logic [BEAT_W-1:0] load_val_i,
    input  logic [BEAT_W-1:0] last_i,
    output logic [BEAT_W-1:0] beat_o
);
    logic [BEAT_W-1:0] beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (!en_i)                 beat_d = '0;
        else if (load_i)           beat_d = load_val_i;
        else if (beat_q >= last_i) beat_d = '0;
        else                       beat_d = beat_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end

    assign beat_o = beat_q;
endmodule

// File: rtl/lmfc_sr_status.sv
module lmfc_sr_status (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic sr_dis_i,
    input  logic rise_i,
    input  logic phase_ok_i,
    input  logic clr_det_i,
    input  logic clr_err_i,
    output logic load_o,
    output logic captured_o,
    output logic detected_o,
    output logic align_err_o
);
    import lmfc_pkg::*;

    sr_status_t st_d, st_q;
    logic       event_c;

    always_comb begin
        event_c = en_i & ~sr_dis_i & rise_i;
        st_d    = st_q;
        if (!en_i) begin
            st_d = '0;
        end else begin
            st_d.captured  = st_q.captured | event_c;
            st_d.detected  = event_c | (st_q.detected & ~clr_det_i);
            st_d.align_err = (event_c & st_q.captured & ~phase_ok_i)
                           | (st_q.align_err & ~clr_err_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign load_o      = event_c & ~st_q.captured;
    assign captured_o  = st_q.captured;
    assign detected_o  = st_q.detected;
    assign align_err_o = st_q.align_err;
endmodule

// File: rtl/lmfc_sysref_align.sv
module lmfc_sysref_align #(
    parameter int CNT_W = 10,
    parameter int DPW   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sysref,
    input  logic             link_en,
    input  logic             sysref_dis,
    input  logic [CNT_W-1:0] mf_len,
    input  logic [CNT_W-1:0] lmfc_ofs,
    input  logic             clr_detect,
    input  logic             clr_align_err,
    output logic             lmfc_edge,
    output logic             lmfc_aligned,
    output logic             sr_detected,
    output logic             sr_align_err
);
    localparam int SHIFT  = $clog2(DPW);
    localparam int BEAT_W = CNT_W - SHIFT;

    logic              rise;
    logic              load;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] last_beat;
    logic [BEAT_W-1:0] ofs_beats;
    logic [BEAT_W:0]   n_beats;
    logic [BEAT_W-1:0] load_val;
    logic [BEAT_W-1:0] ref_phase;
    logic              phase_ok;

    // Beat arithmetic: boundary ofs_beats cycles after the capture cycle's successor.
    always_comb begin
        last_beat = BEAT_W'(mf_len >> SHIFT);
        ofs_beats = BEAT_W'(lmfc_ofs >> SHIFT);
        n_beats   = {1'b0, last_beat} + 1'b1;
        load_val  = (ofs_beats == '0) ? '0 : BEAT_W'(n_beats - {1'b0, ofs_beats});
        ref_phase = (load_val == '0) ? last_beat : load_val - 1'b1;
        phase_ok  = (beat == ref_phase);
    end

    lmfc_sr_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .sysref_i (sysref),
        .rise_o   (rise)
    );

    lmfc_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .en_i       (link_en),
        .load_i     (load),
        .load_val_i (load_val),
        .last_i     (last_beat),
        .beat_o     (beat)
    );

    lmfc_sr_status u_status (
        .clk         (clk),
        .rst         (rst),
        .en_i        (link_en),
        .sr_dis_i    (sysref_dis),
        .rise_i      (rise),
        .phase_ok_i  (phase_ok),
        .clr_det_i   (clr_detect),
        .clr_err_i   (clr_align_err),
        .load_o      (load),
        .captured_o  (lmfc_aligned),
        .detected_o  (sr_detected),
        .align_err_o (sr_align_err)
    );

    assign lmfc_edge = link_en & (beat == '0);
endmodule

// File: rtl/lmfc_sysref_align_chk.sv
module lmfc_sysref_align_chk #(
    parameter int CNT_W = 10,
    parameter int DPW   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sysref,
    input logic             link_en,
    input logic             sysref_dis,
    input logic [CNT_W-1:0] mf_len,
    input logic [CNT_W-1:0] lmfc_ofs,
    input logic             clr_detect,
    input logic             clr_align_err,
    input logic             lmfc_edge,
    input logic             lmfc_aligned,
    input logic             sr_detected,
    input logic             sr_align_err
);
    AST_NO_EDGE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !link_en |-> !lmfc_edge); // R1

    AST_STATUS_CLR_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !link_en |=> (!sr_detected && !sr_align_err && !lmfc_aligned)); // R1

    AST_ALIGNED_STICKY: assert property (@(posedge clk) disable iff (rst)
        (lmfc_aligned && link_en) |=> (lmfc_aligned || !$past(link_en))); // R5

    AST_NO_STATUS_SRDIS: assert property (@(posedge clk) disable iff (rst)
        (sysref_dis && !sr_detected) |=> !sr_detected); // R9

    AST_ERR_AFTER_ALIGN: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_align_err) |-> $past(lmfc_aligned)); // R7
endmodule

bind lmfc_sysref_align lmfc_sysref_align_chk #(.CNT_W(CNT_W), .DPW(DPW)) u_chk (.*);

// File: tb/lmfc_sysref_align_tb.sv
module lmfc_sysref_align_tb;
    localparam int CNT_W = 10;
    localparam int DPW   = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sysref = 1'b0;
    logic             link_en = 1'b0;
    logic             sysref_dis = 1'b0;
    logic [CNT_W-1:0] mf_len = 10'd31;
    logic [CNT_W-1:0] lmfc_ofs = 10'd8;
    logic             clr_detect = 1'b0;
    logic             clr_align_err = 1'b0;
    logic             lmfc_edge, lmfc_aligned, sr_detected, sr_align_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lmfc_sysref_align #(.CNT_W(CNT_W), .DPW(DPW)) u_dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 reset edge", lmfc_edge, 0);
        chk("R1 reset det", sr_detected, 0);
        chk("R1 reset err", sr_align_err, 0);
        chk("R1 reset aligned", lmfc_aligned, 0);
    endtask

    task automatic t_freerun();
        int errs = 0;
        mf_len = 10'd31; sysref_dis = 1'b1; link_en = 1'b1;
        #0.5;
        chk("R2 first enabled cycle edge", lmfc_edge, 1);
        for (int i = 1; i <= 40; i++) begin
            if (i == 5)  sysref = 1'b1;
            if (i == 12) sysref = 1'b0;
            if (i == 20) sysref = 1'b1;
            tick();
            if (lmfc_edge != ((i % 8) == 0)) errs++;
        end
        sysref = 1'b0;
        chk("R2 R9 free-run period unchanged by ignored sysref", errs, 0);
        chk("R9 no detect when disabled", sr_detected, 0);
        chk("R9 no aligned when disabled", lmfc_aligned, 0);
        link_en = 1'b0;
        tick();
        chk("R1 edge low when disabled", lmfc_edge, 0);
        sysref_dis = 1'b0;
    endtask

    task automatic t_capture();
        int errs = 0;
        lmfc_ofs = 10'd8; mf_len = 10'd31; link_en = 1'b1;
        tick(); tick(); tick();
        sysref = 1'b1;              // sampled high at E1 of the loop (i=1 -> E0)
        for (int i = 1; i <= 70; i++) begin
            tick();                 // after posedge E(i-1)
            if (i - 1 >= 3 && lmfc_edge != (((i - 1 - 4) % 8) == 0)) errs++;
            if (i - 1 == 1) chk("R3 det not yet at E1", sr_detected, 0);
            if (i - 1 == 2) begin
                chk("R3 det at E2", sr_detected, 1);
                chk("R5 aligned at E2", lmfc_aligned, 1);
            end
            if (i - 1 == 25) begin
                chk("R10 held sysref no error", sr_align_err, 0);
                sysref = 1'b0;
            end
            if (i - 1 == 31) sysref = 1'b1;   // next sample at E32
            if (i - 1 == 36) chk("R6 aligned later edge no error", sr_align_err, 0);
            if (i - 1 == 40) sysref = 1'b0;
            if (i - 1 == 50) sysref = 1'b1;   // sample at E51, off phase
            if (i - 1 == 52) chk("R7 err not before E2", sr_align_err, 0);
            if (i - 1 == 53) chk("R7 misaligned edge err", sr_align_err, 1);
        end
        sysref = 1'b0;
        chk("R4 R6 R7 boundary positions", errs, 0);
        chk("R5 aligned sticky", lmfc_aligned, 1);
    endtask

    task automatic t_clear();
        clr_align_err = 1'b1;
        tick();
        clr_align_err = 1'b0;
        chk("R8 err cleared", sr_align_err, 0);
        chk("R8 det kept", sr_detected, 1);
        clr_detect = 1'b1;
        tick();
        chk("R8 det cleared", sr_detected, 0);
        sysref = 1'b1;              // E0 at next posedge, clr held
        tick(); tick();
        tick();
        chk("R8 set wins over clear", sr_detected, 1);
        tick();
        chk("R8 clear after set", sr_detected, 0);
        clr_detect = 1'b0;
        sysref = 1'b0;
        link_en = 1'b0;
        tick();
        chk("R1 det cleared on disable", sr_detected, 0);
        chk("R1 aligned cleared on disable", lmfc_aligned, 0);
        tick();
    endtask

    task automatic t_ofs0();
        int errs = 0;
        lmfc_ofs = 10'd0; mf_len = 10'd15; link_en = 1'b1;
        tick(); tick(); tick();
        sysref = 1'b1;
        for (int i = 1; i <= 20; i++) begin
            tick();
            if (i - 1 >= 2 && lmfc_edge != (((i - 1 - 2) % 4) == 0)) errs++;
        end
        sysref = 1'b0;
        chk("R4 zero offset short multiframe", errs, 0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        tick();
        t_freerun();
        t_capture();
        t_clear();
        t_ofs0();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule